// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control core of a nonvolatile SRAM that keeps a shadow copy of its volatile array in nonvolatile cells. It decides when the volatile contents are saved (store) and when they are restored (recall). It then sequences the store engine and the two recall phases. It also gates array accesses while an operation is running. Four inputs drive it, all synchronous to `clk_i`: a supply-good comparator bit, the sampled level of an open-drain active-low store/busy line, a write strobe, and a software command pulse with a store/recall select.

A store starts in three ways: the supply falls below its switch threshold (automatic), an external agent pulls the busy line low (hardware), or software issues a command. Automatic and hardware stores are skipped when nothing was written since the last store or recall. A hardware request first opens a grace window in which the array stays accessible. The block holds the busy line low from the request until the store finishes. A recall clears the array and then copies the nonvolatile contents back in. It starts on software command or when the supply returns. Every duration is a clock-cycle parameter. A one-cycle done pulse marks the end of each completed operation.

Top module: `nvseq_ctrl`

## Requirements
- R1: When `pwr_ok_i` is low in the idle state and the dirty flag is set, a store of STORE_CYC cycles begins at the next edge. It completes even though the supply stays low, and the block then waits in the powered-down state.
- R2: A supply loss or a hardware request leaves `store_en_o` low when the dirty flag is clear. A software store command runs a store whatever the dirty flag holds.
- R3: `access_en_o` is high only in the idle state or the hardware grace window, and only while `pwr_ok_i` is high. A write strobe sampled while it is low has no effect.
- R4: A falling edge on `hsb_i` in the idle state with the dirty flag set opens a grace window of GRACE_CYC cycles with `access_en_o` high, followed by a store of STORE_CYC cycles. `hsb_drive_o` is high for exactly GRACE_CYC+STORE_CYC cycles, and it falls together with the done pulse.
- R5: A recall holds `clr_en_o` high for CLR_CYC cycles and then `xfer_en_o` high for XFER_CYC cycles. At most one of `store_en_o`, `clr_en_o` and `xfer_en_o` is high in any cycle.
- R6: When `pwr_ok_i` rises in the powered-down state, a recall starts at the next edge. `access_en_o` stays low until that recall completes.
- R7: A `sw_cmd_valid_i` pulse in the idle state starts a recall when `sw_cmd_recall_i` is 1 and a store when it is 0.
- R8: The dirty flag sets on a write strobe taken while `access_en_o` is high. It clears when a store or a recall completes.
- R9: When several requests arrive in the same idle cycle, supply loss wins over a hardware request, and a hardware request wins over a software command.
- R10: A hardware request or software command that arrives while an operation is running is dropped and has no later effect.
- R11: `done_o` is high for exactly one cycle, in the first cycle after the last engine cycle of a completed store or recall.
- R12: After reset the block is powered down: `access_en_o`, `store_en_o`, `clr_en_o`, `xfer_en_o`, `hsb_drive_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply above switch threshold |
| hsb_i | input | 1 | Sampled level of the open-drain store/busy line (low = asserted) |
| hsb_drive_o | output | 1 | Pull the store/busy line low |
| wr_strobe_i | input | 1 | Array write attempt this cycle |
| sw_cmd_valid_i | input | 1 | Software command pulse |
| sw_cmd_recall_i | input | 1 | Command select: 1 recall, 0 store |
| access_en_o | output | 1 | Array reads and writes permitted |
| store_en_o | output | 1 | Store engine active |
| clr_en_o | output | 1 | Recall clear phase active |
| xfer_en_o | output | 1 | Recall transfer phase active |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the dirty-flag corners:
- A clean supply loss or hardware request. A design that ignored the flag would run a spurious store.
- A write attempted in the middle of a store. A design that let it through would set the flag, and a later hardware request would then wrongly store.
- A recall followed by a hardware request. If the recall failed to clear the flag, the request would store.

It drives simultaneous supply loss, hardware and software requests. A wrong priority shows up as the wrong engine or as busy-line activity in the next cycle. It issues a command during a running store. A design that queued it would start a recall afterwards. It counts the cycles of each phase. A grace window, clear phase or busy assertion one cycle too long or short, or a transfer phase that does not follow its clear phase, is caught.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    S_DOWN, S_RCL_CLR, S_RCL_XFER, S_IDLE, S_GRACE, S_STORE
  } state_e;

  typedef struct packed {
    logic auto_st;
    logic hw_st;
    logic sw_st;
    logic sw_rc;
  } grant_t;

  localparam int unsigned NUM_REQ = 4;
endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvseq_dirty.sv
module nvseq_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_q <= 1'b0;
    else if (clr_i)  dirty_q <= 1'b0;
    else if (set_i)  dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;

  // R8
  dirty_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dirty_q);

  // R8
  dirty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> dirty_q);

  // R3
  set_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));
endmodule

// File: rtl/nvseq_arb.sv
module nvseq_arb
  import nvseq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   idle_i,
  input  logic   pwr_ok_i,
  input  logic   hsb_i,
  input  logic   dirty_i,
  input  logic   sw_valid_i,
  input  logic   sw_recall_i,
  output grant_t gnt_o
);
  logic               hsb_q;
  logic               hsb_fall;
  logic [NUM_REQ-1:0] req;
  logic [NUM_REQ-1:0] gnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hsb_q <= 1'b1;
    else         hsb_q <= hsb_i;
  end

  assign hsb_fall = hsb_q & ~hsb_i;

  // index order is priority order
  assign req[0] = idle_i & ~pwr_ok_i & dirty_i;
  assign req[1] = idle_i &  pwr_ok_i & hsb_fall & dirty_i;
  assign req[2] = idle_i &  pwr_ok_i & sw_valid_i & ~sw_recall_i;
  assign req[3] = idle_i &  pwr_ok_i & sw_valid_i &  sw_recall_i;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign gnt_o = '{auto_st: gnt[0], hw_st: gnt[1], sw_st: gnt[2], sw_rc: gnt[3]};

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  // R10
  grant_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt != '0) |-> idle_i);
endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 3500,
  parameter int unsigned STORE_CYC = 400000,
  parameter int unsigned CLR_CYC   = 64,
  parameter int unsigned XFER_CYC  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic hsb_i,
  output logic hsb_drive_o,
  input  logic wr_strobe_i,
  input  logic sw_cmd_valid_i,
  input  logic sw_cmd_recall_i,
  output logic access_en_o,
  output logic store_en_o,
  output logic clr_en_o,
  output logic xfer_en_o,
  output logic done_o
);
  localparam int unsigned MAX_AB = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
  localparam int unsigned MAX_CD = (CLR_CYC > XFER_CYC) ? CLR_CYC : XFER_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  localparam logic [CNT_W-1:0] LD_GRACE = CNT_W'(GRACE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_STORE = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CLR   = CNT_W'(CLR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_XFER  = CNT_W'(XFER_CYC - 1);

  state_e           state_q, state_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tmr_zero;
  logic             finish;
  logic             hw_set;
  logic             hw_flag_q;
  logic             done_q;
  logic             dirty;
  logic             idle;
  grant_t           gnt;

  assign idle = (state_q == S_IDLE);

  nvseq_arb i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle),
    .pwr_ok_i   (pwr_ok_i),
    .hsb_i      (hsb_i),
    .dirty_i    (dirty),
    .sw_valid_i (sw_cmd_valid_i),
    .sw_recall_i(sw_cmd_recall_i),
    .gnt_o      (gnt)
  );

  nvseq_timer #(.W(CNT_W)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(tmr_zero)
  );

  nvseq_dirty i_dirty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_strobe_i & access_en_o),
    .clr_i  (finish),
    .dirty_o(dirty)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    finish  = 1'b0;
    hw_set  = 1'b0;
    unique case (state_q)
      S_DOWN: if (pwr_ok_i) begin
        state_d = S_RCL_CLR; ld = 1'b1; ld_val = LD_CLR;
      end
      S_RCL_CLR: begin
        if (!pwr_ok_i) state_d = S_DOWN;
        else if (tmr_zero) begin
          state_d = S_RCL_XFER; ld = 1'b1; ld_val = LD_XFER;
        end
      end
      S_RCL_XFER: begin
        if (!pwr_ok_i) state_d = S_DOWN;
        else if (tmr_zero) begin
          state_d = S_IDLE; finish = 1'b1;
        end
      end
      S_IDLE: begin
        if (!pwr_ok_i) begin
          if (gnt.auto_st) begin
            state_d = S_STORE; ld = 1'b1; ld_val = LD_STORE;
          end else begin
            state_d = S_DOWN;
          end
        end else if (gnt.hw_st) begin
          state_d = S_GRACE; ld = 1'b1; ld_val = LD_GRACE; hw_set = 1'b1;
        end else if (gnt.sw_st) begin
          state_d = S_STORE; ld = 1'b1; ld_val = LD_STORE;
        end else if (gnt.sw_rc) begin
          state_d = S_RCL_CLR; ld = 1'b1; ld_val = LD_CLR;
        end
      end
      S_GRACE: if (!pwr_ok_i || tmr_zero) begin
        state_d = S_STORE; ld = 1'b1; ld_val = LD_STORE;
      end
      S_STORE: if (tmr_zero) begin
        state_d = pwr_ok_i ? S_IDLE : S_DOWN;
        finish  = 1'b1;
      end
      default: state_d = S_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_DOWN;
      done_q    <= 1'b0;
      hw_flag_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (finish)      hw_flag_q <= 1'b0;
      else if (hw_set) hw_flag_q <= 1'b1;
    end
  end

  assign access_en_o = pwr_ok_i & (idle | (state_q == S_GRACE));
  assign store_en_o  = (state_q == S_STORE);
  assign clr_en_o    = (state_q == S_RCL_CLR);
  assign xfer_en_o   = (state_q == S_RCL_XFER);
  assign hsb_drive_o = hw_flag_q;
  assign done_o      = done_q;

  // R3
  access_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_en_o |-> !(store_en_o || clr_en_o || xfer_en_o));

  // R5
  engine_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_en_o, clr_en_o, xfer_en_o}));

  // R5
  clr_before_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_en_o) |-> $past(clr_en_o));

  // R4
  hsb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsb_drive_o) |-> done_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(store_en_o) || $past(xfer_en_o)));

  // R2
  no_clean_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !pwr_ok_i && !dirty) |=> !store_en_o);
endmodule

// File: tb/test_nvseq_ctrl.sv
module test_nvseq_ctrl;
  localparam int GR = 4, ST = 8, CL = 3, XF = 5, WIN = 40, NROW = 8;

  // {kind[2:0], wr, store[4:0], clr[3:0], xfer[3:0], hsb[4:0], done[1:0]}
  // kind: 1 supply loss, 2 hardware request, 3 sw store, 4 sw recall
  localparam logic [23:0] VEC [NROW] = '{
    {3'd3, 1'b0, 5'd8, 4'd0, 4'd0, 5'd0,  2'd1},
    {3'd2, 1'b0, 5'd0, 4'd0, 4'd0, 5'd0,  2'd0},
    {3'd2, 1'b1, 5'd8, 4'd0, 4'd0, 5'd12, 2'd1},
    {3'd1, 1'b1, 5'd8, 4'd3, 4'd5, 5'd0,  2'd2},
    {3'd1, 1'b0, 5'd0, 4'd3, 4'd5, 5'd0,  2'd1},
    {3'd4, 1'b1, 5'd0, 4'd3, 4'd5, 5'd0,  2'd1},
    {3'd2, 1'b0, 5'd0, 4'd0, 4'd0, 5'd0,  2'd0},
    {3'd3, 1'b1, 5'd8, 4'd0, 4'd0, 5'd0,  2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_ok = 1'b0, ext_low = 1'b0, wr = 1'b0, sw_v = 1'b0, sw_r = 1'b0;
  logic hsb_drive, hsb_line, access_en, store_en, clr_en, xfer_en, done;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  assign hsb_line = (hsb_drive | ext_low) ? 1'b0 : 1'b1;

  nvseq_ctrl #(.GRACE_CYC(GR), .STORE_CYC(ST), .CLR_CYC(CL), .XFER_CYC(XF)) i_nvseq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .hsb_i(hsb_line),
    .hsb_drive_o(hsb_drive), .wr_strobe_i(wr), .sw_cmd_valid_i(sw_v),
    .sw_cmd_recall_i(sw_r), .access_en_o(access_en), .store_en_o(store_en),
    .clr_en_o(clr_en), .xfer_en_o(xfer_en), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string row_req(input int i);
    case (i)
      0: return "R2 R7 row0";
      1: return "R2 row1";
      2: return "R4 row2";
      3: return "R1 R6 row3";
      4: return "R2 R6 row4";
      5: return "R5 R7 row5";
      6: return "R8 row6";
      default: return "R7 R11 row7";
    endcase
  endfunction

  task automatic write_once();
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic run_case(input int kind, input bit do_wr,
                          output int n_st, output int n_cl, output int n_xf,
                          output int n_hs, output int n_dn,
                          output int f_cl, output int f_xf);
    n_st = 0; n_cl = 0; n_xf = 0; n_hs = 0; n_dn = 0; f_cl = -1; f_xf = -1;
    if (do_wr) write_once();
    @(negedge clk);
    for (int s = 0; s < WIN; s++) begin
      if (s == 0) begin
        case (kind)
          1: pwr_ok = 1'b0;
          2: ext_low = 1'b1;
          3: begin sw_v = 1'b1; sw_r = 1'b0; end
          4: begin sw_v = 1'b1; sw_r = 1'b1; end
          default: ;
        endcase
      end else if (s == 1) begin
        sw_v = 1'b0;
      end else if (s == 2) begin
        ext_low = 1'b0;
      end else if (s == 20 && kind == 1) begin
        pwr_ok = 1'b1;
      end
      @(negedge clk);
      n_st += int'(store_en); n_cl += int'(clr_en); n_xf += int'(xfer_en);
      n_hs += int'(hsb_drive); n_dn += int'(done);
      if (clr_en && f_cl < 0) f_cl = s;
      if (xfer_en && f_xf < 0) f_xf = s;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a, b, c, d, e, f, g;
    // R12 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 access_en", int'(access_en), 0);
    chk("R12 engines", int'({store_en, clr_en, xfer_en}), 0);
    chk("R12 hsb_drive", int'(hsb_drive), 0);
    chk("R12 done", int'(done), 0);

    // R6 power-up recall
    pwr_ok = 1'b1;
    @(negedge clk);
    chk("R6 clr after rise", int'(clr_en), 1);
    chk("R6 access blocked", int'(access_en), 0);
    repeat (CL) @(negedge clk);
    chk("R5 xfer follows clr", int'(xfer_en), 1);
    chk("R5 clr ended", int'(clr_en), 0);
    repeat (XF) @(negedge clk);
    chk("R6 access after recall", int'(access_en), 1);
    chk("R11 done pulse", int'(done), 1);
    @(negedge clk);
    chk("R11 done one cycle", int'(done), 0);

    // table walk
    for (int i = 0; i < NROW; i++) begin
      run_case(int'(VEC[i][23:21]), VEC[i][20], a, b, c, d, e, f, g);
      chk({row_req(i), " store cycles"}, a, int'(VEC[i][19:15]));
      chk({row_req(i), " clr cycles"},   b, int'(VEC[i][14:11]));
      chk({row_req(i), " xfer cycles"},  c, int'(VEC[i][10:7]));
      chk({row_req(i), " hsb cycles"},   d, int'(VEC[i][6:2]));
      chk({row_req(i), " done pulses"},  e, int'(VEC[i][1:0]));
      if (b != 0) chk("R5 xfer starts after clr", g, f + CL);
    end

    // R3 write during store ignored
    @(negedge clk); sw_v = 1'b1; sw_r = 1'b0;
    @(negedge clk); sw_v = 1'b0;
    chk("R3 store running", int'(store_en), 1);
    chk("R3 access off in store", int'(access_en), 0);
    wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    repeat (12) @(negedge clk);
    run_case(2, 1'b0, a, b, c, d, e, f, g);
    chk("R3 ignored write left clean", a, 0);

    // R10 command during store dropped
    @(negedge clk); sw_v = 1'b1; sw_r = 1'b0;
    @(negedge clk); sw_v = 1'b0;
    @(negedge clk); sw_v = 1'b1; sw_r = 1'b1; ext_low = 1'b1;
    @(negedge clk); sw_v = 1'b0; ext_low = 1'b0;
    b = 0;
    for (int s = 0; s < 20; s++) begin
      @(negedge clk);
      b += int'(clr_en) + int'(hsb_drive);
    end
    chk("R10 dropped request", b, 0);

    // R9 supply loss beats sw recall; R3 supply low gates access
    write_once();
    @(negedge clk); pwr_ok = 1'b0; sw_v = 1'b1; sw_r = 1'b1;
    #1 chk("R3 access off when supply low", int'(access_en), 0);
    @(negedge clk); sw_v = 1'b0;
    chk("R9 supply loss wins store", int'(store_en), 1);
    chk("R9 supply loss no recall", int'(clr_en), 0);
    repeat (10) @(negedge clk);
    chk("R1 down after store", int'(access_en), 0);
    pwr_ok = 1'b1;
    repeat (12) @(negedge clk);

    // R9 hardware beats sw; R4 grace keeps access
    write_once();
    @(negedge clk); ext_low = 1'b1; sw_v = 1'b1; sw_r = 1'b1;
    @(negedge clk); sw_v = 1'b0;
    chk("R9 hw wins busy", int'(hsb_drive), 1);
    chk("R9 hw wins no recall", int'(clr_en), 0);
    chk("R4 grace access", int'(access_en), 1);
    @(negedge clk); ext_low = 1'b0;
    repeat (GR - 1) @(negedge clk);
    chk("R4 store after grace", int'(store_en), 1);
    repeat (ST + 2) @(negedge clk);
    chk("R4 busy released", int'(hsb_drive), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule